// File: doc/BRIEF.md
# Routable Interrupt Controller

This block collects thirty-two interrupt request lines, holds each one as a pending flag, and steers every enabled flag to one of seven processor interrupt lines. Software reaches it through a single-cycle register port: four control words hold a 4-bit route-and-enable field per source, one write-only word clears pending flags, and one read-only word shows all pending flags.

Each source owns its own field, so any source can be sent to any legal line, and several sources may share a line. A line is the OR of the sources steered to it. Its output is registered, so a line follows the pending flags one clock later. A source that stays high sets its flag again straight after a clear, so the line stays up until the source drops or its enable is removed.

Top module: `irq_router`

## Requirements
- R1: After reset, the four control words, the pending word and all interrupt lines read zero.
- R2: Addresses 0 to 3 are control words, and all 32 bits of each can be written and read back. Source n owns bits [(n%8)*4+3:(n%8)*4] of word n/8. A write changes only the addressed word.
- R3: Within a field, bits [2:0] give the destination line and bit 3 is the enable. An enabled pending source with destination k in {0,1,2,3,4,6} drives irq_o[k] high.
- R4: Destination values 5 and 7 drive no line. irq_o[5] never rises.
- R5: A source sampled high on a clock edge sets its pending flag. The flag is set whatever the enable is. Address 5 reads the pending flags with source n at bit n.
- R6: A write to address 4 clears pending flag n for each 1 in bit n. Bits written as 0 leave their flags unchanged.
- R7: If a source is high in the same cycle as a clear of its flag, the flag stays set.
- R8: Each line changes one cycle after the pending flags and fields that feed it. A disabled source drives no line.
- R9: Address 4 reads zero. Writes to address 5 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Interrupt request lines, bit n is source n |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write word address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read word address |
| rd_data_o | output | 32 | Read data, combinational |
| irq_o | output | 7 | Processor interrupt lines 0 to 6 |

## Verification
The hardest case to reach is a clear that lands in the same edge as a still-active source. The bench holds a source high across the clear write and then reads the pending word and the line. The bench also sweeps every source through all sixteen field values, including the two illegal destinations and the disabled cases. For each pass it computes the line expected from the field value and checks the pending flag and the line both before and after a clear.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NSRC    = 32,
  parameter int FIELD_W = 4,
  parameter int NLINE   = 7,
  parameter int AW      = 3,
  parameter int DW      = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [DW-1:0]   rd_data_o,
  output logic [NLINE-1:0] irq_o
);
  localparam int PER_WORD  = DW / FIELD_W;
  localparam int NWORD     = NSRC / PER_WORD;
  localparam int CLR_ADDR  = NWORD;
  localparam int PEND_ADDR = NWORD + 1;
  localparam int RT_W      = FIELD_W - 1;
  localparam logic [7:0] LEGAL = 8'b0101_1111;

  logic [NSRC*FIELD_W-1:0] ctrl_q;
  logic [NSRC-1:0]         pend_q;
  logic [NSRC-1:0]         clr_mask;
  logic [NLINE-1:0]        line_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      for (int w = 0; w < NWORD; w++)
        if (wr_addr_i == AW'(w)) ctrl_q[w*DW +: DW] <= wr_data_i;
    end
  end

  assign clr_mask = (wr_en_i && wr_addr_i == AW'(CLR_ADDR)) ? wr_data_i[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | src_i;
  end

  for (genvar k = 0; k < NLINE; k++) begin : g_line
    if (k < 8 && LEGAL[k]) begin : g_legal
      always_comb begin
        line_d[k] = 1'b0;
        for (int n = 0; n < NSRC; n++)
          if (pend_q[n] && ctrl_q[n*FIELD_W + RT_W] &&
              ctrl_q[n*FIELD_W +: RT_W] == RT_W'(k))
            line_d[k] = 1'b1;
      end
    end else begin : g_tied
      assign line_d[k] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= '0;
    else        irq_o <= line_d;
  end

  always_comb begin
    rd_data_o = '0;
    for (int w = 0; w < NWORD; w++)
      if (rd_addr_i == AW'(w)) rd_data_o = ctrl_q[w*DW +: DW];
    if (rd_addr_i == AW'(PEND_ADDR)) rd_data_o = DW'(pend_q);
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NSRC    = 32,
  parameter int FIELD_W = 4,
  parameter int NLINE   = 7,
  parameter int AW      = 3,
  parameter int DW      = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NSRC-1:0]         src_i,
  input logic                    wr_en_i,
  input logic [AW-1:0]           wr_addr_i,
  input logic [DW-1:0]           wr_data_i,
  input logic [NLINE-1:0]        irq_o,
  input logic [NSRC*FIELD_W-1:0] ctrl_q,
  input logic [NSRC-1:0]         pend_q
);
  logic past_ok;
  logic clr_wr;
  logic [NLINE-1:0] exp_line;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  assign clr_wr = wr_en_i && wr_addr_i == AW'(4);

  always_comb begin
    exp_line = '0;
    for (int n = 0; n < NSRC; n++) begin
      logic [2:0] r;
      r = ctrl_q[n*FIELD_W +: 3];
      if (pend_q[n] && ctrl_q[n*FIELD_W + 3] && r != 3'd5 && r != 3'd7 && int'(r) < NLINE)
        exp_line[r] = 1'b1;
    end
  end

  AST_SRC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((pend_q & $past(src_i)) == $past(src_i))); // R5
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && clr_wr) |=> ((pend_q & $past(wr_data_i[NSRC-1:0] & ~src_i)) == '0)); // R6
  AST_NO_CLR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !clr_wr) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R7
  AST_LINE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (irq_o == $past(exp_line))); // R8
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && wr_en_i && wr_addr_i < AW'(4)) |=>
    (ctrl_q[$past(wr_addr_i)*DW +: DW] == $past(wr_data_i))); // R2
  AST_LINE5_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> !$rose(irq_o[5])); // R4
endmodule

bind irq_router irq_router_chk #(
  .NSRC(NSRC), .FIELD_W(FIELD_W), .NLINE(NLINE), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .irq_o(irq_o),
  .ctrl_q(ctrl_q), .pend_q(pend_q)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [6:0]  irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  function automatic logic [6:0] line_for(logic [3:0] f);
    if (!f[3] || f[2:0] == 3'd5 || f[2:0] == 3'd7) return '0;
    return 7'(1) << f[2:0];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(3'(a), d); check("R1 ctrl", d, 0); end
    rd(3'd5, d); check("R1 pend", d, 0);
    check("R1 irq", 32'(irq), 0);

    // R2 readback and word isolation
    for (int a = 0; a < 4; a++) wr(3'(a), 32'hA5C3_0F10 ^ (32'h1111_1111 * a));
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), d); check("R2 readback", d, 32'hA5C3_0F10 ^ (32'h1111_1111 * a));
    end
    // R9 clear word reads zero, pending word not writable
    rd(3'd4, d); check("R9 clr reads 0", d, 0);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d); check("R9 pend write ignored", d, 0);
    for (int a = 0; a < 4; a++) wr(3'(a), 32'h0);

    // R3 R4 R5 R6 R8 sweep: every source, every field value
    for (int n = 0; n < 32; n++) begin
      for (int f = 0; f < 16; f++) begin
        wr(3'(n/8), 32'(f) << ((n%8)*4));
        src = 32'(1) << n;
        @(negedge clk);
        src = '0;
        rd(3'd5, d); check("R5 pend set", d, 32'(1) << n);
        @(negedge clk);
        check("R3 R4 R8 line", 32'(irq), 32'(line_for(4'(f))));
        wr(3'd4, 32'(1) << n);
        rd(3'd5, d); check("R6 pend cleared", d, 0);
        @(negedge clk);
        check("R8 line drops", 32'(irq), 0);
      end
      wr(3'(n/8), 32'h0);
    end

    // R6 zero bits leave flags; shared line OR
    wr(3'd0, 32'hC << 4);     // src1 -> line 4
    wr(3'd1, 32'hC << 4);     // src9 -> line 4
    src = 32'h0000_0202;
    @(negedge clk); src = '0;
    wr(3'd4, 32'h0);
    rd(3'd5, d); check("R6 zero write keeps", d, 32'h0000_0202);
    wr(3'd4, 32'h0000_0002);
    rd(3'd5, d); check("R6 partial clear", d, 32'h0000_0200);
    @(negedge clk);
    check("R3 shared line", 32'(irq), 32'h10);
    wr(3'd4, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R8 shared line drops", 32'(irq), 0);

    // R7 set wins over clear
    wr(3'd0, 32'hA << 12);    // src3 -> line 2
    src = 32'h8;
    @(negedge clk);
    wr(3'd4, 32'h8);
    rd(3'd5, d); check("R7 set wins", d, 32'h8);
    @(negedge clk);
    check("R7 line held", 32'(irq), 32'h4);
    src = '0;
    wr(3'd4, 32'h8);
    rd(3'd5, d); check("R6 clear after release", d, 0);
    wr(3'd0, 32'h0);
    @(negedge clk);
    check("R8 disabled quiet", 32'(irq), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule